// File: doc/BRIEF.md
# Memory Error Syndrome Capture Register

This block is a 64-bit status register for RAM error reporting. Five RAM error sources feed it: instruction tag, instruction data, data tag, data data and the translation table RAM. In every cycle each source presents an error strobe, a bank/way number, an index and an abort flag. The first error seen while the register is empty fixes a location: the RAM identifier, the bank/way and the index. After that, each later error is sorted as either a repeat of that same location or an error somewhere else, and two saturating 8-bit counters record how many of each have arrived.

Software reads the whole value through a plain read port. A write strobe of any kind clears the register. Each source has only one strobe per cycle, so two errors in the same RAM in the same cycle show up as a single event. When several RAMs report at once, the cycle rules keep every counter step to at most one.

Top module: `mesr_syndrome_reg`

## Requirements
- R1: The read value places the fields as follows: Fatal in bit 63, the other-error count in bits 47:40, the repeat count in bits 39:32, Valid in bit 31, the RAM identifier in bits 30:24, bank/way in bits 22:18 and the index in bits 17:0. Bits 62:48 and bit 23 always read as zero.
- R2: After reset the read value is all zero.
- R3: A cycle with the write strobe high leaves the register all zero on the next cycle. This holds even if error strobes are high in that same cycle, and those errors are dropped.
- R4: An error arriving while Valid is 0 sets Valid, captures that source's bank/way and index, and captures its RAM identifier. The identifiers are source 0 = 0x00 (instruction tag), source 1 = 0x01 (instruction data), source 2 = 0x08 (data tag), source 3 = 0x09 (data data) and source 4 = 0x18 (translation RAM). The repeat count is cleared to zero.
- R5: Once Valid is set, Valid and the captured location do not change until a write.
- R6: Any recorded error whose abort flag is high sets Fatal. Fatal then stays set until a write.
- R7: While Valid is set, an error whose RAM identifier, bank/way and index all equal the captured ones raises the repeat count by one.
- R8: While Valid is set, any non-matching error raises the other-error count. However many sources miss in one cycle, the count rises by exactly one in that cycle.
- R9: If several sources report while Valid is 0, the source with the lowest RAM identifier is captured and the other-error count becomes one. A single first error leaves the other-error count at zero.
- R10: Both counters stop at 0xFF and do not wrap.
- R11: A matching error and a non-matching error in the same cycle raise both counters by one each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_vld | input | 5 | Error strobe per source, bit s belongs to source s |
| err_bank | input | 25 | Bank/way per source, 5 bits each, source s at bits 5s+4:5s |
| err_index | input | 90 | Index per source, 18 bits each, source s at bits 18s+17:18s |
| err_abort | input | 5 | Per-source flag: the error caused a data abort |
| reg_wr | input | 1 | Software write strobe; clears the register |
| reg_rdata | output | 64 | Current register value |

## Verification
The assertions take for granted that reset is held low before the first edge. They also rely on bank/way, index and abort being read only on the cycles when a source's strobe is high, so the properties are written in terms of strobes, the write and the read value. In the stimulus, indexes come from a pool of three values and bank/way from two, so that repeats, misses and mixed cycles all happen often. Writes are rare enough that the counters have time to build up. Directed sequences push both counters into saturation, collide writes with errors, and present first errors from several sources at once.

// File: rtl/mesr_pkg.sv
package mesr_pkg;

   localparam int REG_W      = 64;
   localparam int RAMID_W    = 7;
   localparam int MAX_SRC    = 5;
   localparam int FATAL_BIT  = 63;
   localparam int OTH_LSB    = 40;
   localparam int REP_LSB    = 32;
   localparam int VALID_BIT  = 31;
   localparam int RAMID_LSB  = 24;
   localparam int BANK_LSB   = 18;
   localparam int INDEX_LSB  = 0;
   localparam int BANK_MAX_W = 5;
   localparam int INDEX_MAX_W = 18;
   localparam int CNT_MAX_W  = 8;

   // Identifier per source position; ascending order is also capture priority.
   function automatic logic [RAMID_W-1:0] ram_id(input int src);
      case (src)
         0:       ram_id = 7'h00;
         1:       ram_id = 7'h01;
         2:       ram_id = 7'h08;
         3:       ram_id = 7'h09;
         4:       ram_id = 7'h18;
         default: ram_id = 7'h7F;
      endcase
   endfunction

endpackage

// File: rtl/mesr_first_sel.sv
module mesr_first_sel #(
   parameter int N = 5,
   localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic [SEL_W-1:0] sel,
   output logic             any,
   output logic             multi
);

   int unsigned hits;

   always_comb begin
      sel  = '0;
      hits = 0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            sel  = SEL_W'(i);
            hits = hits + 1;
         end
      end
      any   = |req;
      multi = (hits > 1);
   end

endmodule

// File: rtl/mesr_match.sv
module mesr_match #(
   parameter int N       = 5,
   parameter int BANK_W  = 5,
   parameter int INDEX_W = 18
) (
   input  logic [N-1:0]                    err_vld,
   input  logic [N*BANK_W-1:0]             err_bank,
   input  logic [N*INDEX_W-1:0]            err_index,
   input  logic [mesr_pkg::RAMID_W-1:0]    cap_id,
   input  logic [BANK_W-1:0]               cap_bank,
   input  logic [INDEX_W-1:0]              cap_index,
   output logic                            hit,
   output logic                            miss
);

   logic [N-1:0] hit_v;
   logic [N-1:0] miss_v;

   for (genvar s = 0; s < N; s++) begin : g_cmp
      localparam logic [mesr_pkg::RAMID_W-1:0] SRC_ID = mesr_pkg::ram_id(s);
      logic same_loc;
      assign same_loc  = (SRC_ID == cap_id)
                      && (err_bank[s*BANK_W +: BANK_W] == cap_bank)
                      && (err_index[s*INDEX_W +: INDEX_W] == cap_index);
      assign hit_v[s]  = err_vld[s] &&  same_loc;
      assign miss_v[s] = err_vld[s] && !same_loc;
   end

   assign hit  = |hit_v;
   assign miss = |miss_v;

endmodule

// File: rtl/mesr_sat_cnt.sv
module mesr_sat_cnt #(
   parameter int W        = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   logic [W-1:0] stepped;

   if (SATURATE) begin : g_sat
      assign stepped = (&cnt) ? cnt : cnt + W'(1);
   end else begin : g_wrap
      assign stepped = cnt + W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (load)  cnt <= load_val;
      else if (inc)   cnt <= stepped;
   end

endmodule

// File: rtl/mesr_syndrome_reg.sv
module mesr_syndrome_reg #(
   parameter int NUM_SRC  = 5,
   parameter int BANK_W   = 5,
   parameter int INDEX_W  = 18,
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SRC-1:0]         err_vld,
   input  logic [NUM_SRC*BANK_W-1:0]  err_bank,
   input  logic [NUM_SRC*INDEX_W-1:0] err_index,
   input  logic [NUM_SRC-1:0]         err_abort,
   input  logic                       reg_wr,
   output logic [63:0]                reg_rdata
);
   import mesr_pkg::*;

   localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("NUM_SRC out of range");
   end
   if (BANK_W < 1 || BANK_W > BANK_MAX_W) begin : g_bad_bank
      $error("BANK_W does not fit its field");
   end
   if (INDEX_W < 1 || INDEX_W > INDEX_MAX_W) begin : g_bad_index
      $error("INDEX_W does not fit its field");
   end
   if (CNT_W < 1 || CNT_W > CNT_MAX_W) begin : g_bad_cnt
      $error("CNT_W does not fit its field");
   end

   logic                 valid_q, fatal_q;
   logic [RAMID_W-1:0]   id_q;
   logic [BANK_W-1:0]    bank_q;
   logic [INDEX_W-1:0]   index_q;
   logic [CNT_W-1:0]     rep_cnt, oth_cnt;

   logic [SEL_W-1:0]     first_sel;
   logic                 first_any, first_multi;
   logic                 loc_hit, loc_miss;
   logic                 capture, abort_seen;

   mesr_first_sel #(.N(NUM_SRC)) u_first (
      .req   (err_vld),
      .sel   (first_sel),
      .any   (first_any),
      .multi (first_multi)
   );

   mesr_match #(.N(NUM_SRC), .BANK_W(BANK_W), .INDEX_W(INDEX_W)) u_match (
      .err_vld   (err_vld),
      .err_bank  (err_bank),
      .err_index (err_index),
      .cap_id    (id_q),
      .cap_bank  (bank_q),
      .cap_index (index_q),
      .hit       (loc_hit),
      .miss      (loc_miss)
   );

   assign capture    = !reg_wr && !valid_q && first_any;
   assign abort_seen = !reg_wr && |(err_vld & err_abort);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         fatal_q <= 1'b0;
         id_q    <= '0;
         bank_q  <= '0;
         index_q <= '0;
      end else if (reg_wr) begin
         valid_q <= 1'b0;
         fatal_q <= 1'b0;
         id_q    <= '0;
         bank_q  <= '0;
         index_q <= '0;
      end else begin
         if (capture) begin
            valid_q <= 1'b1;
            id_q    <= ram_id(int'(first_sel));
            bank_q  <= err_bank[int'(first_sel)*BANK_W +: BANK_W];
            index_q <= err_index[int'(first_sel)*INDEX_W +: INDEX_W];
         end
         if (abort_seen) fatal_q <= 1'b1;
      end
   end

   mesr_sat_cnt #(.W(CNT_W), .SATURATE(SATURATE)) u_rep (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (reg_wr),
      .load     (capture),
      .load_val ('0),
      .inc      (valid_q && loc_hit),
      .cnt      (rep_cnt)
   );

   mesr_sat_cnt #(.W(CNT_W), .SATURATE(SATURATE)) u_oth (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (reg_wr),
      .load     (capture),
      .load_val (first_multi ? CNT_W'(1) : CNT_W'(0)),
      .inc      (valid_q && loc_miss),
      .cnt      (oth_cnt)
   );

   always_comb begin
      reg_rdata                          = '0;
      reg_rdata[FATAL_BIT]               = fatal_q;
      reg_rdata[OTH_LSB +: CNT_W]        = oth_cnt;
      reg_rdata[REP_LSB +: CNT_W]        = rep_cnt;
      reg_rdata[VALID_BIT]               = valid_q;
      reg_rdata[RAMID_LSB +: RAMID_W]    = id_q;
      reg_rdata[BANK_LSB +: BANK_W]      = bank_q;
      reg_rdata[INDEX_LSB +: INDEX_W]    = index_q;
   end

endmodule

// File: rtl/mesr_checker.sv
module mesr_checker #(
   parameter int NUM_SRC  = 5,
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] err_vld,
   input logic               reg_wr,
   input logic [63:0]        reg_rdata
);
   import mesr_pkg::*;

   logic             valid;
   logic             fatal;
   logic [CNT_W-1:0] rep;
   logic [CNT_W-1:0] oth;
   logic [30:0]      loc;

   assign valid = reg_rdata[VALID_BIT];
   assign fatal = reg_rdata[FATAL_BIT];
   assign rep   = reg_rdata[REP_LSB +: CNT_W];
   assign oth   = reg_rdata[OTH_LSB +: CNT_W];
   assign loc   = reg_rdata[30:0];

   p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[62:48] == 15'd0 && !reg_rdata[23]);

   p_write_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> reg_rdata == 64'd0);

   p_first_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && !valid && |err_vld) |=> (valid && rep == '0));

   p_location_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && valid) |=> (valid && $stable(loc)));

   p_fatal_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && fatal) |=> fatal);

   p_rep_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && valid) |=> (rep == $past(rep) || rep == $past(rep) + 1'b1));

   p_oth_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && valid) |=> (oth == $past(oth) || oth == $past(oth) + 1'b1));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && err_vld == '0) |=> $stable(reg_rdata));

   if (SATURATE) begin : g_sat_chk
      p_no_wrap_rep_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (!reg_wr && valid && &rep) |=> &rep);
      p_no_wrap_oth_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (!reg_wr && valid && &oth) |=> &oth);
   end

endmodule

bind mesr_syndrome_reg mesr_checker #(
   .NUM_SRC  (NUM_SRC),
   .CNT_W    (CNT_W),
   .SATURATE (SATURATE)
) u_mesr_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .err_vld   (err_vld),
   .reg_wr    (reg_wr),
   .reg_rdata (reg_rdata)
);

// File: tb/test_mesr_syndrome_reg.sv
module test_mesr_syndrome_reg;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  err_vld = '0;
   logic [24:0] err_bank = '0;
   logic [89:0] err_index = '0;
   logic [4:0]  err_abort = '0;
   logic        reg_wr = 1'b0;
   logic [63:0] reg_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [63:0] exp_val = '0;

   always #4 clk = ~clk;

   mesr_syndrome_reg i_mesr_syndrome_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .err_vld   (err_vld),
      .err_bank  (err_bank),
      .err_index (err_index),
      .err_abort (err_abort),
      .reg_wr    (reg_wr),
      .reg_rdata (reg_rdata)
   );

   function automatic logic [6:0] src_id(input int s);
      logic [6:0] ids [5] = '{7'h00, 7'h01, 7'h08, 7'h09, 7'h18};
      return ids[s];
   endfunction

   // Next register value computed from the requirements.
   function automatic logic [63:0] model_next(input logic [63:0] cur,
         input logic [4:0] v, input logic [24:0] b, input logic [89:0] ix,
         input logic [4:0] ab, input logic w);
      logic [63:0] n;
      logic [7:0]  rep, oth;
      bit hit, miss;
      int first, nsrc;
      if (w) return 64'd0;
      if (v == 5'd0) return cur;
      n = cur;
      rep = cur[39:32];
      oth = cur[47:40];
      if (|(v & ab)) n[63] = 1'b1;
      if (!cur[31]) begin
         first = -1;
         nsrc = 0;
         for (int s = 4; s >= 0; s--) if (v[s]) begin first = s; nsrc++; end
         n[31]    = 1'b1;
         n[30:24] = src_id(first);
         n[22:18] = b[first*5 +: 5];
         n[17:0]  = ix[first*18 +: 18];
         rep = 8'd0;
         oth = (nsrc > 1) ? 8'd1 : 8'd0;
      end else begin
         hit = 0;
         miss = 0;
         for (int s = 0; s < 5; s++) if (v[s]) begin
            if (src_id(s) == cur[30:24] && b[s*5 +: 5] == cur[22:18]
                && ix[s*18 +: 18] == cur[17:0]) hit = 1;
            else miss = 1;
         end
         if (hit && rep != 8'hFF) rep = rep + 8'd1;
         if (miss && oth != 8'hFF) oth = oth + 8'd1;
      end
      n[39:32] = rep;
      n[47:40] = oth;
      return n;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic step(input logic [4:0] v, input logic [24:0] b, input logic [89:0] ix,
                       input logic [4:0] ab, input logic w, input string tag);
      @(negedge clk);
      err_vld = v; err_bank = b; err_index = ix; err_abort = ab; reg_wr = w;
      exp_val = model_next(exp_val, v, b, ix, ab, w);
      @(posedge clk);
      #1;
      check(tag, reg_rdata, exp_val);
   endtask

   task automatic one_err(input int s, input logic [4:0] bk, input logic [17:0] id,
                          input logic ab, input string tag);
      logic [24:0] b = '0;
      logic [89:0] ix = '0;
      logic [4:0]  v = '0;
      logic [4:0]  a = '0;
      b[s*5 +: 5] = bk;
      ix[s*18 +: 18] = id;
      v[s] = 1'b1;
      a[s] = ab;
      step(v, b, ix, a, 1'b0, tag);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [24:0] b;
      logic [89:0] ix;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      check("R2 reset value", reg_rdata, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R4: first error on data-data source
      one_err(3, 5'd4, 18'h2A5A5, 1'b0, "R4 first capture");
      check("R4 ram id 0x09", {57'd0, reg_rdata[30:24]}, 64'h09);
      check("R1 index field", {46'd0, reg_rdata[17:0]}, 64'h2A5A5);
      check("R1 bank field", {59'd0, reg_rdata[22:18]}, 64'd4);
      // R7 exact repeat
      one_err(3, 5'd4, 18'h2A5A5, 1'b0, "R7 repeat");
      check("R7 repeat count 1", {56'd0, reg_rdata[39:32]}, 64'd1);
      // R8 miss on index
      one_err(3, 5'd4, 18'h2A5A4, 1'b0, "R8 other");
      // R8 several misses in one cycle count once
      b = {5'd1, 5'd4, 5'd2, 5'd3, 5'd4};
      ix = '0;
      step(5'b10111, b, ix, 5'd0, 1'b0, "R8 multi miss");
      check("R8 other count 2", {56'd0, reg_rdata[47:40]}, 64'd2);
      // R11 hit and miss together
      b = '0; ix = '0;
      b[15 +: 5] = 5'd4; ix[54 +: 18] = 18'h2A5A5;
      step(5'b01001, b, ix, 5'd0, 1'b0, "R11 hit and miss");
      // R6 fatal from abort, then sticky
      one_err(1, 5'd0, 18'h1, 1'b1, "R6 fatal set");
      check("R6 fatal bit", {63'd0, reg_rdata[63]}, 64'd1);
      step(5'd0, '0, '0, 5'd0, 1'b0, "R6 fatal sticky");
      step(5'd0, '0, '0, 5'd0, 1'b0, "R5 idle hold");
      // R3 write beats errors in the same cycle
      step(5'b11111, '1, '1, 5'b11111, 1'b1, "R3 write with errors");
      // R9 simultaneous first errors: lowest id wins
      b = '0; ix = '0;
      b[10 +: 5] = 5'd7; ix[36 +: 18] = 18'h00F0F;
      b[15 +: 5] = 5'd9; ix[54 +: 18] = 18'h11111;
      step(5'b11100, b, ix, 5'd0, 1'b0, "R9 simultaneous first");
      check("R9 captured id 0x08", {57'd0, reg_rdata[30:24]}, 64'h08);
      check("R9 other count 1", {56'd0, reg_rdata[47:40]}, 64'd1);
      // R10 saturation of both counters
      for (int k = 0; k < 300; k++) one_err(2, 5'd7, 18'h00F0F, 1'b0, "R10 repeat sat");
      for (int k = 0; k < 300; k++) one_err(4, 5'd1, 18'h00003, 1'b0, "R10 other sat");
      check("R10 repeat 0xFF", {56'd0, reg_rdata[39:32]}, 64'hFF);
      check("R10 other 0xFF", {56'd0, reg_rdata[47:40]}, 64'hFF);
      step(5'd0, '0, '0, 5'd0, 1'b1, "R3 write clears");
      // Random mix
      for (int k = 0; k < 4000; k++) begin
         logic [4:0] v, a;
         for (int s = 0; s < 5; s++) begin
            v[s] = ($urandom % 4) == 0;
            a[s] = ($urandom % 24) == 0;
            b[s*5 +: 5] = 5'($urandom % 2);
            ix[s*18 +: 18] = 18'($urandom % 3);
         end
         step(v, b, ix, a, ($urandom % 48) == 0, "R5 random mix");
         check("R1 reserved bits", {reg_rdata[62:48], reg_rdata[23]}, 64'd0);
      end
      finish_run();
   end

endmodule